// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for a synchronous burst memory. A cycle begins when either of two start strobes is sampled high on a rising clock edge: the external address is captured and presented as the current address on the next cycle. From then on the block derives further addresses by itself. Each clock edge that sees the advance input high, with no start strobe, moves the low address bits one step through a four-word group. The bits above that group stay fixed.

A static order select chooses how the low bits move through the group. In linear order they count upward and wrap modulo four. In interleaved order they are the loaded low bits XOR a step count. Bursting is optional, so a start strobe on every cycle loads a fresh address each cycle with no dead cycle. The current address is held in a register and is driven straight from it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is sampled high on a rising edge, `cur_addr` is zero in the following cycle, and the step count restarts at zero.
- R2: When `start_a` or `start_b` is sampled high, `cur_addr` equals the sampled `ext_addr` in the next cycle, and the step count k restarts at 0.
- R3: With `order_sel` = 0 (linear), each edge with `advance` = 1 and no start strobe increments k. The low two bits of `cur_addr` become (loaded low bits + k) mod 4.
- R4: With `order_sel` = 1 (interleaved), each such edge increments k. The low two bits of `cur_addr` become (loaded low bits) XOR (k mod 4).
- R5: An edge with no start strobe and `advance` = 0 leaves `cur_addr` unchanged.
- R6: Without a start strobe, the bits of `cur_addr` above bit 1 never change.
- R7: A start strobe takes precedence over `advance`. This holds when both strobes are high together, and when a strobe and `advance` are high together. The address is loaded and k restarts at 0.
- R8: After four advances from a load, `cur_addr` returns to the loaded address, and the sequence repeats within the same aligned four-word group.
- R9: Start strobes on consecutive edges load a new address on every cycle with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | Externally supplied start address |
| start_a | input | 1 | First start strobe; loads `ext_addr` |
| start_b | input | 1 | Second start strobe; loads `ext_addr` |
| advance | input | 1 | Steps the burst position when no strobe is present |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| cur_addr | output | ADDR_W | Registered current word address |

## Verification
The step counter and the registered base address are invisible at the ports. A corrupted step count shows up as a wrong low-bit pair on the very next advance. A corrupted base shows up either in the upper bits or in every later offset of the same burst. Because `cur_addr` is a register loaded from next-state logic, every fault appears exactly one cycle after the edge that caused it. A bench that compares `cur_addr` with a model on every cycle therefore pins each fault to a single edge. A wrong precedence between a strobe and `advance` shows up as an address off by one step instead of the freshly loaded value.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    cnt_nxt = cnt_q;
    if (load)      cnt_nxt = '0;
    else if (step) cnt_nxt = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // Counter behaviour relative to its own inputs over time
  AST_CTR_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == '0);                                   // R2
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> cnt_q == $past(cnt_q) + ONE);        // R3
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt_q));                    // R5

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_lo,
  input  logic [CNT_W-1:0] step_k,
  input  burst_order_e     order,
  output logic [CNT_W-1:0] offs_lo
);

  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] ilv_lo;

  // Linear: modular sum; interleaved: bitwise XOR per position
  assign lin_lo = base_lo + step_k;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign ilv_lo[b] = base_lo[b] ^ step_k[b];
  end

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: offs_lo = ilv_lo;
      default:        offs_lo = lin_lo;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              start_a,
  input  logic              start_b,
  input  logic              advance,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int HI_W = ADDR_W - CNT_W;

  logic              load;
  logic              step;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  offs_lo;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  burst_order_e      order;

  assign load  = start_a | start_b;
  assign step  = advance & ~load;
  assign order = burst_order_e'(order_sel);

  burst_step_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .base_lo (base_q[CNT_W-1:0]),
    .step_k  (cnt_nxt),
    .order   (order),
    .offs_lo (offs_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      addr_q <= ext_addr;
    end else if (step) begin
      addr_q <= {base_q[ADDR_W-1:CNT_W], offs_lo};
    end
  end

  assign cur_addr = addr_q;

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (start_a || start_b) |=> cur_addr == $past(ext_addr));   // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!start_a && !start_b && !advance) |=> $stable(cur_addr)); // R5
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!start_a && !start_b) |=>
      cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W])); // R6
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!start_a && !start_b && advance && !order_sel && !$past(order_sel)) |=>
      cur_addr[CNT_W-1:0] == $past(cur_addr[CNT_W-1:0]) + CNT_W'(1)); // R3
  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (rst)
    (start_a && start_b && advance) |=> cur_addr == $past(ext_addr)); // R7

  initial begin
    AST_WIDTHS: assert (HI_W >= 0 && CNT_W >= 1);
  end

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int AW = 20;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          start_a, start_b, advance, order_sel;
  logic [AW-1:0] cur_addr;

  int n_chk  = 0;
  int n_fail = 0;
  int seed_s;

  logic [AW-1:0] m_base;
  logic [CW-1:0] m_k;
  logic          m_ilv;
  logic [AW-1:0] m_hold;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .start_a(start_a),
    .start_b(start_b), .advance(advance), .order_sel(order_sel),
    .cur_addr(cur_addr)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [CW-1:0] k, logic ilv);
    logic [CW-1:0] lo;
    lo = ilv ? (b[CW-1:0] ^ k) : (b[CW-1:0] + k);
    return {b[AW-1:CW], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] exp);
    n_chk++;
    if (cur_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: cur_addr=%h expected=%h", tag, cur_addr, exp);
    end
  endtask

  // Drive one cycle at negedge, update the model for the coming edge,
  // then check at the next negedge.
  task automatic cyc(logic sa, logic sb, logic adv, logic ilv,
                     logic [AW-1:0] a, string tag);
    ext_addr = a; start_a = sa; start_b = sb; advance = adv; order_sel = ilv;
    if (sa || sb) begin
      m_base = a; m_k = '0; m_ilv = ilv;
      m_hold = a;
    end else if (adv) begin
      m_k = m_k + 1'b1; m_ilv = ilv;
      m_hold = exp_addr(m_base, m_k, m_ilv);
    end
    @(negedge clk);
    check(tag, m_hold);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: cur_addr=%h expected=completion", cur_addr);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] a0;
    seed_s = $urandom(32'h5eed_1234);
    rst = 1'b1; ext_addr = '0; start_a = 0; start_b = 0; advance = 0; order_sel = 0;
    m_base = '0; m_k = '0; m_ilv = 0; m_hold = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst = 1'b0;

    // R3 linear walk with wrap (R8), load via start_a
    cyc(1, 0, 0, 0, 20'hABC46, "R2 load a");
    cyc(0, 0, 1, 0, '0, "R3 lin +1");
    cyc(0, 0, 1, 0, '0, "R3 lin +2");
    cyc(0, 0, 0, 0, '0, "R5 hold");
    cyc(0, 0, 1, 0, '0, "R3 lin +3");
    cyc(0, 0, 1, 0, '0, "R8 wrap");
    check("R8 back to start", 20'hABC46);
    cyc(0, 0, 1, 0, '0, "R6 upper fixed");

    // R4 interleaved walk, load via start_b
    cyc(0, 1, 0, 1, 20'h12347, "R2 load b");
    cyc(0, 0, 1, 1, '0, "R4 ilv ^1");
    check("R4 ilv value", 20'h12346);
    cyc(0, 0, 1, 1, '0, "R4 ilv ^2");
    check("R4 ilv value", 20'h12345);
    cyc(0, 0, 1, 1, '0, "R4 ilv ^3");
    check("R4 ilv value", 20'h12344);
    cyc(0, 0, 1, 1, '0, "R8 ilv wrap");
    check("R8 ilv back", 20'h12347);

    // R7 precedence
    cyc(0, 0, 1, 1, '0, "R4 step before strobe");
    cyc(1, 1, 1, 1, 20'h0F0F2, "R7 both strobes + advance");
    check("R7 loaded exact", 20'h0F0F2);
    cyc(1, 0, 1, 0, 20'h55551, "R7 strobe + advance");
    cyc(0, 0, 1, 0, '0, "R7 count restarted");
    check("R7 first step", 20'h55552);

    // R9 back-to-back loads
    for (int i = 0; i < 8; i++) begin
      a0 = AW'($urandom());
      cyc(i[0], ~i[0], 0, 0, a0, "R9 back-to-back");
    end

    // R1 reset mid-burst
    cyc(0, 0, 1, 0, '0, "R3 pre-reset step");
    rst = 1'b1; advance = 1'b1;
    @(negedge clk);
    m_base = '0; m_k = '0; m_hold = '0;
    check("R1 reset mid-burst", '0);
    rst = 1'b0;
    cyc(0, 0, 1, 0, '0, "R1 count restarted");
    check("R1 step from zero", 20'h00001);

    // Random mix; order changes only together with a load
    for (int i = 0; i < 3000; i++) begin
      logic sa, sb, adv, ilv;
      sa  = ($urandom() % 5) == 0;
      sb  = ($urandom() % 6) == 0;
      adv = ($urandom() % 3) != 0;
      ilv = (sa || sb) ? logic'($urandom() % 2) : m_ilv;
      cyc(sa, sb, adv, ilv, AW'($urandom()),
          (sa || sb) ? "R2 rand load" : (adv ? (ilv ? "R4 rand step" : "R3 rand step")
                                             : "R5 rand hold"));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule